// File: doc/BRIEF.md
# Dual-Line Asynchronous Serial Frame Monitor

This block passively observes two independent asynchronous serial lines, one carrying the receive direction and one the transmit direction. It turns the traffic on each line into a stream of tagged events. Each line has its own frame engine. The engine waits for a falling edge on an idle-high line and times every bit from that edge. It samples each bit at its centre and assembles 5 to 9 data bits, in LSB-first or MSB-first order. It then checks an optional parity bit of a selectable type and judges the stop bit.

Every sampled bit position yields exactly one event. An event carries a three-bit kind code, a channel tag and a value. Events from both engines are merged onto a single valid/ready output. When both engines produce an event in the same cycle, the receive event goes out first and the transmit event waits in its own holding slot. All configuration inputs are shared by the two lines and are read live, so they are expected to stay constant while a frame is in flight.

Top module: `serial_pair_decoder`

## Requirements
- R1: After reset `ev_valid` is low. The first synchronized line sample after reset only seeds the previous-level register, so a line held low through reset and then raised produces no event.
- R2: A falling edge on an idle engine starts a frame. The start-bit event is presented after the (3 + floor(cfg_cpb/2))-th rising clock edge that follows the line's falling transition. The data event is presented exactly N*cfg_cpb edges later, where N is the data length. cfg_cpb must be at least 4.
- R3: The data length N is taken from cfg_nbits (5 to 9). The data event (kind 1) carries the word in its low N bits with all higher bits zero. With cfg_msb_first=0 the first data bit on the line lands in bit 0. With cfg_msb_first=1 the first data bit on the line lands in bit N-1.
- R4: cfg_parity selects the parity type: 0 none, 1 odd, 2 even, 3 always-zero, 4 always-one. For odd and even, the ones in the data plus the parity bit must total odd or even respectively. A parity bit that matches gives a kind 2 event whose value is the received bit.
- R5: A parity bit that does not match gives a kind 6 event. Its value bit 1 is the expected parity bit, bit 0 is the received bit, and the higher bits are zero.
- R6: With cfg_parity=0 no parity bit is sampled and the stop bit directly follows the data, so a frame gives exactly three events.
- R7: A start bit read as 0 at its centre gives kind 0 with value 0. A start bit read as 1 gives kind 4 with value 1, and the rest of the frame is still decoded.
- R8: A stop bit read as 1 gives kind 3 with value 1. A stop bit read as 0 gives kind 5 with value 0. In both cases the engine then returns to waiting for the next falling edge.
- R9: Events of one frame leave in the order start, data, parity (if any), stop. `ev_chan` is 0 for the receive line and 1 for the transmit line.
- R10: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_kind`, `ev_chan` and `ev_value` stay unchanged.
- R11: If both engines raise an event in the same cycle, the receive event is offered first and the transmit event is offered next. No event is lost as long as `ev_ready` is never low for more than floor(cfg_cpb/2)-1 cycles at a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_rx | input | 1 | Receive-direction serial line (asynchronous) |
| line_tx | input | 1 | Transmit-direction serial line (asynchronous) |
| cfg_cpb | input | CPB_W | Clock cycles per bit, at least 4 |
| cfg_nbits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity | input | 3 | Parity type code, 0 to 4 |
| cfg_msb_first | input | 1 | 1 selects MSB-first data order |
| ev_ready | input | 1 | Consumer accepts the offered event |
| ev_valid | output | 1 | An event is offered |
| ev_kind | output | 3 | Event kind code |
| ev_chan | output | 1 | 0 receive line, 1 transmit line |
| ev_value | output | VAL_W | Event value |

## Verification
The assertions take for granted three things about the inputs. The configuration must stay inside its legal ranges: cfg_cpb of at least 4, a data length of 5 to 9, and a parity code of 4 or less. Frames must not be malformed in timing. The consumer must never stall longer than about half a bit period, which is the condition under which a holding slot cannot be refilled before it drains. The stimulus changes the configuration only between frames, while both lines are idle. It applies periodic back-pressure of three cycles in eight, and only at a 16-clock bit period, so every stall ends well before the next event of the same line. Malformed start, parity and stop bits are produced by driving the line levels at bit centres, never by breaking the bit timing.

// File: rtl/serial_pair_decoder.sv
`timescale 1ns/1ps
module serial_pair_decoder #(
  parameter int CPB_W = 16,
  parameter int VAL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_rx,
  input  logic             line_tx,
  input  logic [CPB_W-1:0] cfg_cpb,
  input  logic [3:0]       cfg_nbits,
  input  logic [2:0]       cfg_parity,
  input  logic             cfg_msb_first,
  input  logic             ev_ready,
  output logic             ev_valid,
  output logic [2:0]       ev_kind,
  output logic             ev_chan,
  output logic [VAL_W-1:0] ev_value
);

  localparam int NCH = 2;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  logic [NCH-1:0]   line_in, fire, pend, pop;
  logic [2:0]       fire_kind [NCH];
  logic [VAL_W-1:0] fire_val  [NCH];
  logic [2:0]       pend_kind [NCH];
  logic [VAL_W-1:0] pend_val  [NCH];
  logic [CPB_W-1:0] half_m1, full_m1;
  logic [3:0]       last_idx;
  logic             hold_tx;

  assign line_in  = {line_tx, line_rx};
  assign half_m1  = (cfg_cpb >> 1) - 1'b1;
  assign full_m1  = cfg_cpb - 1'b1;
  assign last_idx = cfg_nbits - 4'd1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             s1, s2, prev;
    logic [1:0]       warm;
    phase_t           ph;
    logic [CPB_W-1:0] cnt;
    logic [3:0]       idx;
    logic [VAL_W-1:0] sh, sh_nx;
    logic             want_p, at_ctr, f;
    logic [2:0]       fk;
    logic [VAL_W-1:0] fv;

    assign at_ctr = (ph != PH_IDLE) && (cnt == '0);

    always_comb begin
      if (cfg_msb_first) begin
        sh_nx = {sh[VAL_W-2:0], s2};
      end else begin
        sh_nx = sh >> 1;
        sh_nx[last_idx] = s2;
      end
    end

    always_comb begin
      case (cfg_parity)
        3'd1:    want_p = ~(^sh);
        3'd2:    want_p = ^sh;
        3'd3:    want_p = 1'b0;
        default: want_p = 1'b1;
      endcase
    end

    always_comb begin
      f  = 1'b0;
      fk = 3'd0;
      fv = '0;
      if (at_ctr) begin
        case (ph)
          PH_START: begin
            f  = 1'b1;
            fk = s2 ? 3'd4 : 3'd0;
            fv = VAL_W'(s2);
          end
          PH_DATA: begin
            f  = (idx == last_idx);
            fk = 3'd1;
            fv = sh_nx;
          end
          PH_PAR: begin
            f  = 1'b1;
            fk = (s2 != want_p) ? 3'd6 : 3'd2;
            fv = (s2 != want_p) ? VAL_W'({want_p, s2}) : VAL_W'(s2);
          end
          PH_STOP: begin
            f  = 1'b1;
            fk = s2 ? 3'd3 : 3'd5;
            fv = VAL_W'(s2);
          end
          default: ;
        endcase
      end
    end

    assign fire[g]      = f;
    assign fire_kind[g] = fk;
    assign fire_val[g]  = fv;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        prev <= 1'b1;
        warm <= '0;
        ph   <= PH_IDLE;
        cnt  <= '0;
        idx  <= '0;
        sh   <= '0;
      end else begin
        s1   <= line_in[g];
        s2   <= s1;
        prev <= s2;
        if (warm != 2'd3) warm <= warm + 2'd1;
        if (ph == PH_IDLE) begin
          if (warm == 2'd3 && prev && !s2) begin
            ph  <= PH_START;
            cnt <= half_m1;
          end
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= full_m1;
          case (ph)
            PH_START: begin
              ph  <= PH_DATA;
              idx <= '0;
              sh  <= '0;
            end
            PH_DATA: begin
              sh <= sh_nx;
              if (idx == last_idx) ph <= (cfg_parity == 3'd0) ? PH_STOP : PH_PAR;
              else idx <= idx + 4'd1;
            end
            PH_PAR:  ph <= PH_STOP;
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end

    p_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pend[g] && !pop[g] |-> !fire[g]);
  end

  assign ev_valid = |pend;
  assign ev_chan  = pend[1] && (hold_tx || !pend[0]);
  assign ev_kind  = pend_kind[ev_chan];
  assign ev_value = pend_val[ev_chan];
  assign pop[0]   = ev_ready && pend[0] && !ev_chan;
  assign pop[1]   = ev_ready && ev_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      hold_tx <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        pend_kind[c] <= '0;
        pend_val[c]  <= '0;
      end
    end else begin
      hold_tx <= ev_valid && !ev_ready && ev_chan;
      for (int c = 0; c < NCH; c++) begin
        if (fire[c]) begin
          pend[c]      <= 1'b1;
          pend_kind[c] <= fire_kind[c];
          pend_val[c]  <= fire_val[c];
        end else if (pop[c]) begin
          pend[c] <= 1'b0;
        end
      end
    end
  end

  p_cfg_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cpb >= CPB_W'(4) && cfg_nbits >= 4'd5 && cfg_nbits <= 4'd9 && cfg_parity <= 3'd4);

  p_data_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == 3'd1 |-> (ev_value >> cfg_nbits) == '0);

  p_perr_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_kind == 3'd6 |-> (ev_value[1] != ev_value[0]) && (ev_value >> 2) == '0);

  p_kind_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_kind <= 3'd6);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_kind) && $stable(ev_chan) && $stable(ev_value));

  p_rx_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] && fire[1] |=> ev_valid && !ev_chan && pend[1]);

endmodule

// File: tb/serial_pair_decoder_test.sv
`timescale 1ns/1ps
module serial_pair_decoder_test;

  typedef struct packed {
    logic [7:0] cpb;
    logic [3:0] nb;
    logic [2:0] par;
    logic       msb;
    logic       ch;
    logic [8:0] word;
    logic       bs;
    logic       bp;
    logic       bt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd16, 4'd8, 3'd0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0},
    '{8'd16, 4'd8, 3'd1, 1'b0, 1'b1, 9'h053, 1'b0, 1'b0, 1'b0},
    '{8'd16, 4'd8, 3'd2, 1'b1, 1'b0, 9'h0C3, 1'b0, 1'b0, 1'b0},
    '{8'd16, 4'd5, 3'd3, 1'b0, 1'b1, 9'h015, 1'b0, 1'b0, 1'b0},
    '{8'd16, 4'd9, 3'd4, 1'b1, 1'b0, 9'h1A7, 1'b0, 1'b0, 1'b0},
    '{8'd16, 4'd7, 3'd2, 1'b0, 1'b0, 9'h05B, 1'b0, 1'b1, 1'b0},
    '{8'd16, 4'd8, 3'd1, 1'b0, 1'b1, 9'h0FF, 1'b0, 1'b1, 1'b0},
    '{8'd16, 4'd6, 3'd0, 1'b0, 1'b0, 9'h02D, 1'b1, 1'b0, 1'b0},
    '{8'd16, 4'd8, 3'd0, 1'b1, 1'b1, 9'h081, 1'b0, 1'b0, 1'b1},
    '{8'd5,  4'd8, 3'd2, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0},
    '{8'd7,  4'd9, 3'd3, 1'b1, 1'b1, 9'h155, 1'b0, 1'b1, 1'b0},
    '{8'd6,  4'd5, 3'd4, 1'b0, 1'b0, 9'h01F, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_rx = 1'b1, line_tx = 1'b1;
  logic [15:0] cfg_cpb = 16'd16;
  logic [3:0]  cfg_nbits = 4'd8;
  logic [2:0]  cfg_parity = 3'd0;
  logic        cfg_msb_first = 1'b0;
  logic        ev_ready = 1'b1;
  logic        ev_valid, ev_chan;
  logic [2:0]  ev_kind;
  logic [8:0]  ev_value;

  always #2.5 clk = ~clk;

  serial_pair_decoder uut (
    .clk(clk), .rst_n(rst_n), .line_rx(line_rx), .line_tx(line_tx),
    .cfg_cpb(cfg_cpb), .cfg_nbits(cfg_nbits), .cfg_parity(cfg_parity),
    .cfg_msb_first(cfg_msb_first), .ev_ready(ev_ready), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .ev_chan(ev_chan), .ev_value(ev_value)
  );

  int checks = 0, fails = 0;
  int gcount = 0, ecount = 0;
  logic [2:0] got_k [64];
  logic       got_c [64];
  logic [8:0] got_v [64];
  logic [2:0] exp_k [64];
  logic       exp_c [64];
  logic [8:0] exp_v [64];
  bit stall_on = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    ev_ready = stall_on ? ((cyc % 8) >= 3) : 1'b1;
  end

  logic held = 1'b0;
  logic [2:0] hk;
  logic hc;
  logic [8:0] hv;
  always @(negedge clk) begin
    if (held) begin
      checks++;
      if (!ev_valid || ev_kind != hk || ev_chan != hc || ev_value != hv) begin
        fails++;
        $display("FAIL R10 held event changed: actual v=%0d k=%0d c=%0d val=%0h expected v=1 k=%0d c=%0d val=%0h",
                 ev_valid, ev_kind, ev_chan, ev_value, hk, hc, hv);
      end
    end
    held = ev_valid && !ev_ready;
    hk = ev_kind;
    hc = ev_chan;
    hv = ev_value;
    if (ev_valid && ev_ready && gcount < 64) begin
      got_k[gcount] = ev_kind;
      got_c[gcount] = ev_chan;
      got_v[gcount] = ev_value;
      gcount++;
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd0, 3'd4: return "R7";
      3'd1:       return "R3";
      3'd2:       return "R4";
      3'd6:       return "R5";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic exp_par(logic [8:0] w, logic [3:0] nb, logic [2:0] par);
    logic [8:0] m;
    logic x;
    m = (9'h1 << nb) - 9'h1;
    x = ^(w & m);
    case (par)
      3'd1:    return ~x;
      3'd2:    return x;
      3'd3:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic push_exp(logic [2:0] k, logic c, logic [8:0] v);
    exp_k[ecount] = k;
    exp_c[ecount] = c;
    exp_v[ecount] = v;
    ecount++;
  endtask

  task automatic add_frame_events(vec_t v, logic c);
    logic p;
    p = exp_par(v.word, v.nb, v.par);
    if (v.bs) push_exp(3'd4, c, 9'd1); else push_exp(3'd0, c, 9'd0);
    push_exp(3'd1, c, v.word);
    if (v.par != 3'd0) begin
      if (v.bp) push_exp(3'd6, c, {7'd0, p, ~p});
      else      push_exp(3'd2, c, {8'd0, p});
    end
    if (v.bt) push_exp(3'd5, c, 9'd0); else push_exp(3'd3, c, 9'd1);
  endtask

  task automatic set_line(logic c, logic val);
    if (c) line_tx = val; else line_rx = val;
  endtask

  task automatic send_frame(vec_t v, logic c);
    int cp;
    cp = int'(v.cpb);
    set_line(c, 1'b0);
    if (v.bs) begin
      tick(1);
      set_line(c, 1'b1);
      tick(cp - 1);
    end else tick(cp);
    for (int i = 0; i < int'(v.nb); i++) begin
      set_line(c, v.msb ? v.word[int'(v.nb) - 1 - i] : v.word[i]);
      tick(cp);
    end
    if (v.par != 3'd0) begin
      set_line(c, exp_par(v.word, v.nb, v.par) ^ v.bp);
      tick(cp);
    end
    set_line(c, !v.bt);
    tick(cp);
    set_line(c, 1'b1);
    tick(2 * cp);
  endtask

  task automatic apply_cfg(vec_t v);
    cfg_cpb = {8'd0, v.cpb};
    cfg_nbits = v.nb;
    cfg_parity = v.par;
    cfg_msb_first = v.msb;
  endtask

  task automatic verify(string cnt_req);
    int n;
    chk(gcount == ecount, cnt_req, "event count", gcount, ecount);
    n = (gcount < ecount) ? gcount : ecount;
    for (int i = 0; i < n; i++) begin
      chk(got_k[i] == exp_k[i], req_of(exp_k[i]), "event kind", got_k[i], exp_k[i]);
      chk(got_c[i] == exp_c[i], "R9", "event channel", got_c[i], exp_c[i]);
      chk(got_v[i] == exp_v[i], req_of(exp_k[i]), "event value", got_v[i], exp_v[i]);
    end
  endtask

  task automatic do_reset(logic lvl);
    line_rx = lvl;
    line_tx = lvl;
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic timing_test(vec_t v);
    int t_start, t_data, half;
    t_start = -1;
    t_data = -1;
    half = int'(v.cpb) / 2;
    apply_cfg(v);
    gcount = 0;
    ecount = 0;
    add_frame_events(v, 1'b0);
    fork
      send_frame(v, 1'b0);
      begin
        int n;
        n = 0;
        while (n < 2000) begin
          @(posedge clk);
          n++;
          @(negedge clk);
          if (ev_valid && ev_kind == 3'd0 && t_start < 0) t_start = n;
          if (ev_valid && ev_kind == 3'd1) begin
            t_data = n;
            break;
          end
        end
      end
    join
    tick(8);
    chk(t_start == 3 + half, "R2", "edges to start event", t_start, 3 + half);
    chk(t_data == 3 + half + int'(v.nb) * int'(v.cpb), "R2", "edges to data event",
        t_data, 3 + half + int'(v.nb) * int'(v.cpb));
    verify("R9");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    vec_t dv;
    logic [2:0] tk [8];
    logic [8:0] tv [8];
    int nt;

    // R1: reset state, and a line held low through reset is not an edge
    do_reset(1'b0);
    @(negedge clk);
    chk(ev_valid == 1'b0, "R1", "ev_valid after reset", ev_valid, 0);
    tick(1);
    gcount = 0;
    tick(48);
    chk(gcount == 0, "R1", "events with line low from reset", gcount, 0);
    line_rx = 1'b1;
    line_tx = 1'b1;
    tick(40);
    chk(gcount == 0, "R1", "events after line rises", gcount, 0);

    // R2: sampling instants
    timing_test('{8'd16, 4'd8, 3'd0, 1'b0, 1'b0, 9'h0B4, 1'b0, 1'b0, 1'b0});
    timing_test('{8'd5,  4'd5, 3'd1, 1'b0, 1'b0, 9'h013, 1'b0, 1'b0, 1'b0});

    // R3..R9: table of frames; back-pressure on some (R10)
    for (int i = 0; i < NV; i++) begin
      apply_cfg(VECS[i]);
      stall_on = (i >= 6) && (VECS[i].cpb >= 8'd16);
      tick(2);
      gcount = 0;
      ecount = 0;
      add_frame_events(VECS[i], VECS[i].ch);
      send_frame(VECS[i], VECS[i].ch);
      tick(8);
      stall_on = 1'b0;
      tick(2);
      verify((VECS[i].par == 3'd0) ? "R6" : "R9");
    end

    // R11: both lines in the same cycle, receive offered first
    dv = '{8'd16, 4'd8, 3'd2, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0};
    apply_cfg(dv);
    tick(2);
    gcount = 0;
    ecount = 0;
    add_frame_events(dv, 1'b0);
    nt = ecount;
    for (int i = 0; i < nt; i++) begin
      tk[i] = exp_k[i];
      tv[i] = exp_v[i];
    end
    ecount = 0;
    for (int i = 0; i < nt; i++) begin
      push_exp(tk[i], 1'b0, tv[i]);
      push_exp(tk[i], 1'b1, tv[i]);
    end
    fork
      send_frame(dv, 1'b0);
      send_frame(dv, 1'b1);
    join
    tick(8);
    verify("R11");

    // R11 with back-pressure on both lines at once
    stall_on = 1'b1;
    gcount = 0;
    ecount = 0;
    for (int i = 0; i < nt; i++) begin
      push_exp(tk[i], 1'b0, tv[i]);
      push_exp(tk[i], 1'b1, tv[i]);
    end
    fork
      send_frame(dv, 1'b0);
      send_frame(dv, 1'b1);
    join
    tick(8);
    stall_on = 1'b0;
    tick(2);
    verify("R11");

    summary();
    $finish;
  end

endmodule